// File: doc/BRIEF.md
# Two-Level Delay-and-Sum Beamformer

This block forms one beam from sixteen signed antenna sample streams. The streams are split into four groups of four. Each group enters an identical tile: every tile input passes through its own programmable delay line, and a registered four-input adder sums the four delayed samples. A fifth tile of the same kind forms the top level. It delays each group's partial sum by that group's common delay and adds the four results into the beam.

The common delay of a group is the smallest full delay among its elements. Software programs only the residual per element (full delay minus the group's common delay), and programs the common delay once per group. This keeps every delay line short. Element 0 serves as the zero-delay reference, so no delay is needed after the top adder.

Every line holds at most DEPTH past samples. A longer common delay, such as 12 in a linear profile, is handled by adding the excess to the residuals of that group's four elements. Time advances only on cycles with the sample strobe high, and delays count accepted samples.

Top module: `dsum_beam_tree`

## Requirements
- R1: After reset every residual and common delay is 0, and `beam`, `beam_vld` and `cfg_rej` are 0.
- R2: A configuration write to address 0..15 sets the residual delay of element e = address; element e belongs to group e/4. A write to address 16..19 sets the common delay of group address-16. An accepted value takes effect from the next cycle.
- R3: A write whose data exceeds DEPTH (8), or whose address is 20 or above, changes no delay and does not restart the fill count. One cycle later `cfg_rej` is high for exactly one cycle. Accepted writes leave `cfg_rej` low.
- R4: An element with residual delay r contributes the sample it received r accepted samples earlier. A residual of 0 passes the current sample straight to the adder.
- R5: Group g's partial sum is delayed by its common delay before the top adder.
- R6: After the strobed edge that accepts sample n, `beam` (signed, SAMPLE_W+4 bits) equals the sum over all elements e of x_e[n-1-c_g-r_e]. This holds without overflow, including all-minimum and all-maximum inputs.
- R7: Let k count the strobed edges since the last accepted write or reset, starting at 0. `beam_vld` is set at a strobed edge when k is greater than the largest c_g+r_e. An accepted write clears `beam_vld` in the next cycle and restarts k.
- R8: While `smp_en` is low, no delay line or adder advances, and `beam` and `beam_vld` hold their values.
- R9: A linear profile with element e delayed by e gives the exact beam. It is programmed with common delays 0, 4, 8 and 8, residuals e%4 in groups 0..2, and residuals 4..7 in group 3. The alternative common delay of 12 is refused.
- R10: Residual and common delays of exactly DEPTH on every line give the correct beam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe; the whole datapath advances only when it is high |
| smp_in | input | 192 | Sixteen signed 12-bit samples; element e occupies bits [12e+11:12e] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Delay register address (0..15 residuals, 16..19 common delays) |
| cfg_data | input | 4 | Delay value in samples |
| beam | output | 16 | Signed beam sum |
| beam_vld | output | 1 | Beam valid once every line is filled to its programmed depth |
| cfg_rej | output | 1 | One-cycle pulse flagging a refused write |

## Verification
The hardest case to reach is a delay that sits exactly at the buffer edge on both levels at once. In that case the read pointer of every line wraps onto the slot about to be overwritten, and the fill count must reach its highest threshold before valid rises. The bench programs a delay of 8 into all twenty registers and streams random data long enough to pass that threshold.

The bench also inserts gaps in the sample strobe so that delays are counted in samples rather than cycles. Full-scale constant inputs in both signs probe the width growth. Refused writes are interleaved with streaming, and their lack of effect is confirmed from the beam values that follow.

// File: rtl/dsum_pkg.sv
package dsum_pkg;
  // bits needed to hold a delay from 0 up to and including depth
  function automatic int dly_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  // extra adder bits for summing n operands without overflow
  function automatic int sum_growth(input int n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/dsum_delay_line.sv
module dsum_delay_line #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int DLY_W = dsum_pkg::dly_bits(DEPTH),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [W-1:0]     din,
  input  logic [DLY_W-1:0] dly,
  output logic [W-1:0]     dout
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rd_idx;

  always_comb begin
    wp_d = wp_q;
    if (en) wp_d = wp_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  // storage is not reset
  always_ff @(posedge clk) begin
    if (en) mem[wp_q] <= din;
  end

  // DEPTH is a power of two, so a delay of DEPTH wraps onto the oldest slot
  assign rd_idx = wp_q - dly[PTR_W-1:0];
  assign dout   = (dly == '0) ? din : mem[rd_idx];

  // R3
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly <= DLY_W'(DEPTH));
endmodule

// File: rtl/dsum_tile.sv
module dsum_tile #(
  parameter int IN_N  = 4,
  parameter int IN_W  = 12,
  parameter int DEPTH = 8,
  localparam int DLY_W = dsum_pkg::dly_bits(DEPTH),
  localparam int OUT_W = IN_W + dsum_pkg::sum_growth(IN_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [IN_N*IN_W-1:0]  din,
  input  logic [IN_N*DLY_W-1:0] dly,
  output logic [OUT_W-1:0]      sum_q
);
  localparam int EXT_W = OUT_W - IN_W;

  logic [IN_N*IN_W-1:0] tap;
  logic [OUT_W-1:0]     sum_d;

  for (genvar k = 0; k < IN_N; k++) begin : g_line
    dsum_delay_line #(.W(IN_W), .DEPTH(DEPTH)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .din  (din[k*IN_W +: IN_W]),
      .dly  (dly[k*DLY_W +: DLY_W]),
      .dout (tap[k*IN_W +: IN_W])
    );
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < IN_N; k++) begin
      sum_d = sum_d + {{EXT_W{tap[k*IN_W+IN_W-1]}}, tap[k*IN_W +: IN_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum_q <= '0;
    else if (en) sum_q <= sum_d;
  end
endmodule

// File: rtl/dsum_cfg_regs.sv
module dsum_cfg_regs #(
  parameter int ELEM_N  = 16,
  parameter int GROUP_N = 4,
  parameter int DEPTH   = 8,
  localparam int DLY_W  = dsum_pkg::dly_bits(DEPTH),
  localparam int ADDR_W = $clog2(ELEM_N + GROUP_N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DLY_W-1:0]         cfg_data,
  output logic [ELEM_N*DLY_W-1:0]  res_q,
  output logic [GROUP_N*DLY_W-1:0] grp_q,
  output logic                     cfg_ok,
  output logic                     rej_q
);
  localparam logic [DLY_W-1:0]  DEPTH_V = DLY_W'(DEPTH);
  localparam logic [ADDR_W-1:0] NREG_V  = ADDR_W'(ELEM_N + GROUP_N);

  logic [ELEM_N*DLY_W-1:0]  res_d;
  logic [GROUP_N*DLY_W-1:0] grp_d;
  logic                     rej_d;

  assign cfg_ok = cfg_we && (cfg_data <= DEPTH_V) && (cfg_addr < NREG_V);
  assign rej_d  = cfg_we && !cfg_ok;

  always_comb begin
    res_d = res_q;
    grp_d = grp_q;
    for (int e = 0; e < ELEM_N; e++) begin
      if (cfg_ok && cfg_addr == ADDR_W'(e)) res_d[e*DLY_W +: DLY_W] = cfg_data;
    end
    for (int g = 0; g < GROUP_N; g++) begin
      if (cfg_ok && cfg_addr == ADDR_W'(ELEM_N + g)) grp_d[g*DLY_W +: DLY_W] = cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      grp_q <= '0;
      rej_q <= 1'b0;
    end else begin
      res_q <= res_d;
      grp_q <= grp_d;
      rej_q <= rej_d;
    end
  end

  // R3
  rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_ok) |=> ($stable(res_q) && $stable(grp_q)));
  // R3
  rej_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> $past(cfg_we));
endmodule

// File: rtl/dsum_beam_tree.sv
module dsum_beam_tree #(
  parameter int SAMPLE_W = 12,
  parameter int SUB_N    = 4,
  parameter int GROUP_N  = 4,
  parameter int DEPTH    = 8,
  localparam int ELEM_N  = SUB_N * GROUP_N,
  localparam int DLY_W   = dsum_pkg::dly_bits(DEPTH),
  localparam int ADDR_W  = $clog2(ELEM_N + GROUP_N + 1),
  localparam int PSUM_W  = SAMPLE_W + dsum_pkg::sum_growth(SUB_N),
  localparam int BEAM_W  = PSUM_W + dsum_pkg::sum_growth(GROUP_N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_en,
  input  logic [ELEM_N*SAMPLE_W-1:0] smp_in,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DLY_W-1:0]           cfg_data,
  output logic [BEAM_W-1:0]          beam,
  output logic                       beam_vld,
  output logic                       cfg_rej
);
  localparam int CNT_MAX = 2 * DEPTH + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX_V = CNT_W'(CNT_MAX);

  logic [ELEM_N*DLY_W-1:0]   res_dly;
  logic [GROUP_N*DLY_W-1:0]  grp_dly;
  logic                      cfg_ok;
  logic [GROUP_N*PSUM_W-1:0] psum;
  logic [DLY_W:0]            tot, maxtot;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      vld_q, vld_d;

  dsum_cfg_regs #(.ELEM_N(ELEM_N), .GROUP_N(GROUP_N), .DEPTH(DEPTH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .cfg_data(cfg_data),
    .res_q   (res_dly),
    .grp_q   (grp_dly),
    .cfg_ok  (cfg_ok),
    .rej_q   (cfg_rej)
  );

  // lower level: one tile per group, residual delays on the element inputs
  for (genvar g = 0; g < GROUP_N; g++) begin : g_sub
    dsum_tile #(.IN_N(SUB_N), .IN_W(SAMPLE_W), .DEPTH(DEPTH)) u_tile (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (smp_en),
      .din  (smp_in[g*SUB_N*SAMPLE_W +: SUB_N*SAMPLE_W]),
      .dly  (res_dly[g*SUB_N*DLY_W +: SUB_N*DLY_W]),
      .sum_q(psum[g*PSUM_W +: PSUM_W])
    );
  end

  // upper level: common group delays on the partial sums
  dsum_tile #(.IN_N(GROUP_N), .IN_W(PSUM_W), .DEPTH(DEPTH)) u_top (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (smp_en),
    .din  (psum),
    .dly  (grp_dly),
    .sum_q(beam)
  );

  // largest end-to-end delay over all elements
  always_comb begin
    maxtot = '0;
    tot    = '0;
    for (int e = 0; e < ELEM_N; e++) begin
      tot = {1'b0, res_dly[e*DLY_W +: DLY_W]} + {1'b0, grp_dly[(e/SUB_N)*DLY_W +: DLY_W]};
      if (tot > maxtot) maxtot = tot;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (cfg_ok) begin
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (smp_en) begin
      vld_d = cnt_q > CNT_W'(maxtot);
      if (cnt_q != CNT_MAX_V) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign beam_vld = vld_q;

  // R7
  vld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> !beam_vld);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !cfg_ok) |=> ($stable(beam) && $stable(beam_vld)));
endmodule

// File: tb/dsum_beam_tree_tb.sv
module dsum_beam_tree_tb;
  localparam int SW = 12, GN = 4, SN = 4, EN = 16, DEPTH = 8, DW = 4, AW = 5, BW = 16;
  localparam int CNT_MAX = 2 * DEPTH + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_en;
  logic [EN*SW-1:0] smp_in;
  logic cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_data;
  logic [BW-1:0] beam;
  logic beam_vld, cfg_rej;

  always #5 clk = ~clk;

  dsum_beam_tree u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .beam(beam), .beam_vld(beam_vld), .cfg_rej(cfg_rej)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int res [EN];
  int grp [GN];
  int hist [EN][$];
  int cnt = 0;
  int exp_beam = 0;
  bit exp_vld = 1'b0, exp_rej = 1'b0;
  string tag = "R1";

  function automatic int maxtot();
    int m = 0;
    for (int e = 0; e < EN; e++) if (res[e] + grp[e/SN] > m) m = res[e] + grp[e/SN];
    return m;
  endfunction

  task automatic chk(string t, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, expv, $time);
    end
  endtask

  task automatic compare();
    chk(tag, "beam_vld", int'(beam_vld), int'(exp_vld));
    chk(tag, "cfg_rej", int'(cfg_rej), int'(exp_rej));
    if (exp_vld) chk(tag, "beam", int'($signed(beam)), exp_beam);
  endtask

  // mode 0 random, 1 all minimum, 2 all maximum
  task automatic step(bit en, int mode);
    int v [EN];
    smp_en = en;
    cfg_we = 1'b0;
    for (int e = 0; e < EN; e++) begin
      if (mode == 1)      v[e] = -(1 << (SW-1));
      else if (mode == 2) v[e] = (1 << (SW-1)) - 1;
      else                v[e] = int'($urandom_range(0, (1 << SW) - 1)) - (1 << (SW-1));
      smp_in[e*SW +: SW] = SW'(v[e]);
    end
    @(posedge clk);
    exp_rej = 1'b0;
    if (en) begin
      for (int e = 0; e < EN; e++) hist[e].push_back(v[e]);
      exp_vld = cnt > maxtot();
      if (exp_vld) begin
        int m = hist[0].size() - 1;
        exp_beam = 0;
        for (int e = 0; e < EN; e++) begin
          int idx = m - 1 - grp[e/SN] - res[e];
          if (idx >= 0) exp_beam += hist[e][idx];
        end
      end
      if (cnt < CNT_MAX) cnt++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic cfg(int addr, int data);
    bit ok;
    smp_en = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = AW'(addr);
    cfg_data = DW'(data);
    @(posedge clk);
    ok = (addr < EN + GN) && (data <= DEPTH);
    if (ok) begin
      if (addr < EN) res[addr] = data; else grp[addr-EN] = data;
      cnt = 0;
      exp_vld = 1'b0;
    end
    exp_rej = !ok;
    @(negedge clk);
    cfg_we = 1'b0;
    compare();
  endtask

  task automatic run(int n, int mode, bit gaps);
    for (int i = 0; i < n; i++) step(gaps ? ($urandom_range(0, 3) != 0) : 1'b1, mode);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < EN; e++) res[e] = 0;
    for (int g = 0; g < GN; g++) grp[g] = 0;
    rst_n = 1'b0; smp_en = 1'b0; smp_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "reset beam", int'(beam), 0);
    chk("R1", "reset beam_vld", int'(beam_vld), 0);
    chk("R1", "reset cfg_rej", int'(cfg_rej), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // zero delays: valid from the second sample, beam is plain sum of previous sample
    tag = "R1";
    run(3, 0, 1'b0);
    tag = "R6";
    run(30, 0, 1'b0);

    // linear profile; 12 is refused as a common delay, out-of-range address too
    tag = "R9";
    cfg(EN + 3, 12);
    tag = "R3";
    cfg(25, 3);
    run(5, 0, 1'b0);
    tag = "R2";
    for (int e = 0; e < EN; e++) cfg(e, (e / SN == 3) ? (e % SN) + 4 : e % SN);
    cfg(EN + 0, 0);
    cfg(EN + 1, 4);
    cfg(EN + 2, 8);
    cfg(EN + 3, 8);
    tag = "R7";
    run(17, 0, 1'b0);
    tag = "R9";
    run(40, 0, 1'b0);
    tag = "R8";
    run(60, 0, 1'b1);
    tag = "R3";
    cfg(5, 9);
    run(20, 0, 1'b0);

    // residual-only delays
    tag = "R4";
    for (int g = 0; g < GN; g++) cfg(EN + g, 0);
    for (int e = 0; e < EN; e++) cfg(e, (e * 5) % 9);
    run(40, 0, 1'b0);

    // common-only delays
    tag = "R5";
    for (int e = 0; e < EN; e++) cfg(e, 0);
    for (int g = 0; g < GN; g++) cfg(EN + g, 7 - 2 * g);
    run(40, 0, 1'b1);

    // every line at full depth
    tag = "R10";
    for (int a = 0; a < EN + GN; a++) cfg(a, DEPTH);
    run(60, 0, 1'b0);
    run(40, 0, 1'b1);

    // full-scale inputs
    tag = "R6";
    run(25, 1, 1'b0);
    run(25, 2, 1'b0);

    // accepted write mid-stream drops valid and restarts the count
    tag = "R7";
    cfg(3, 2);
    run(30, 0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule